// File: doc/BRIEF.md
# Dual-rate seed-XOR scan pattern sequencer

This block produces the serial scan data for a low-power logic self-test. It has one data bit per scan chain. It keeps an m-bit maximal-length shift-register sequence as a per-pattern seed. It also keeps an L-bit Johnson counter that can either count or rotate. While a chain is loaded, each chain k receives seed bit k XORed with the Johnson bit currently at the rotation output. Because the Johnson word changes by a single bit from one pattern to the next, the loaded patterns have few transitions.

A single clock drives the block, and two clock enables give it two rates. The fast enable steps the Johnson counter and shifts scan data. The slow enable advances the seed, once per complete Johnson count cycle. Each pattern frame has three parts: one count cycle, then L shift cycles with scan enable high, then one capture cycle. The capture cycle also carries the pattern-done pulse. Generation begins on a start request and then runs without stopping until reset.

Top module: `scan_seed_seq`

## Requirements
- R1: While reset is active, and after reset until start_i is seen high on a clock edge, scan_en_o, pattern_done_o, seed_step_o, fast_step_o and scan_data_o are all 0.
- R2: Each pattern frame is exactly one count cycle (scan_en_o=0), then L consecutive shift cycles (scan_en_o=1), then one capture cycle (scan_en_o=0), followed immediately by the next frame's count cycle.
- R3: The Johnson width L equals CHAIN_LEN, or M_CHAINS when CHAIN_LEN < M_CHAINS. With the defaults (CHAIN_LEN=6, M_CHAINS=4), L=6.
- R4: In shift cycle i (i=0..L-1) of a frame, scan_data_o[k] = seed[k] XOR J[L-1-i], where J is the Johnson word of that frame. Outside shift cycles scan_data_o is 0.
- R5: The Johnson word resets to all zeros. The count cycle of every frame sets J to {J[L-2:0], ~J[L-1]}. The L rotations of a frame leave J unchanged.
- R6: The seed resets to SEED (default 4'b0001) and advances as seed = {seed[m-2:0], ^(seed & TAPS)}. The default TAPS=4'b1100 gives period 2^m-1 = 15.
- R7: The seed advances once every 2L frames. seed_step_o is high in the capture cycle of frames whose index mod 2L equals 2L-1, and the new seed applies from the next frame.
- R8: fast_step_o is high in count and shift cycles and low in capture cycles.
- R9: pattern_done_o is a one-cycle pulse in the capture cycle that follows the last shift of every frame.
- R10: start_i has no effect once generation runs. The frame sequence repeats with period (2^m-1)*2L frames, so with the defaults frame 180 equals frame 0.
- R11: Asserting rst_ni during generation returns all outputs to 0. A later start reproduces frame 0 exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins generation when seen in idle |
| scan_data_o | output | M_CHAINS | Serial data, one bit per chain |
| scan_en_o | output | 1 | High during shift cycles |
| pattern_done_o | output | 1 | One-cycle pulse in the capture cycle |
| seed_step_o | output | 1 | Slow enable: seed advances this cycle |
| fast_step_o | output | 1 | Fast enable: Johnson count or shift this cycle |

## Verification
The bench follows about 190 frames against an independent model. This covers the frame where the seed first advances, and a bad frame counter would advance the seed one frame early or late. It also checks the wrap of the Johnson count from all ones back to all zeros; a counter that rotated without inverting would stick at one word. The bench then compares frame 180 with frame 0 to catch a wrong full period. It also checks the bit order within a shift. If the rotation direction or its tap were reversed, chain data would come out mirrored, and that only shows once J is not symmetric. Finally, it checks a reset during generation followed by a restart, and an idle period with start held low, where a design that left the idle state early would put shift traffic on the outputs.

// File: rtl/scan_seed_pkg.sv
package scan_seed_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_SHIFT = 2'd2,
    ST_CAPT  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/seed_lfsr.sv
module seed_lfsr #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] TAPS = 4'b1100,
  parameter logic [W-1:0] SEED = 4'b0001
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] seed_o
);
  logic [W-1:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     s_q <= SEED;
    else if (step_i) s_q <= {s_q[W-2:0], ^(s_q & TAPS)};
  end

  assign seed_o = s_q;
endmodule

// File: rtl/johnson_rcfg.sv
module johnson_rcfg #(
  parameter int unsigned L = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         count_i,   // 1: Johnson count, 0: rotate
  output logic         msb_o
);
  logic [L-1:0] j_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       j_q <= '0;
    else if (en_i) begin
      if (count_i)     j_q <= {j_q[L-2:0], ~j_q[L-1]};
      else             j_q <= {j_q[L-2:0], j_q[L-1]};
    end
  end

  assign msb_o = j_q[L-1];
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import scan_seed_pkg::*;
#(
  parameter int unsigned L = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic count_o,
  output logic shift_o,
  output logic capt_o,
  output logic seed_step_o
);
  localparam int unsigned SCW = (L > 1) ? $clog2(L) : 1;
  localparam int unsigned PCW = $clog2(2 * L);
  localparam logic [SCW-1:0] SHIFT_LAST = SCW'(L - 1);
  localparam logic [PCW-1:0] PAT_LAST   = PCW'(2 * L - 1);

  seq_state_e   st_q, st_d;
  logic [SCW-1:0] sc_q;
  logic [PCW-1:0] pc_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_i) st_d = ST_COUNT;
      ST_COUNT: st_d = ST_SHIFT;
      ST_SHIFT: if (sc_q == SHIFT_LAST) st_d = ST_CAPT;
      ST_CAPT:  st_d = ST_COUNT;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      sc_q <= '0;
      pc_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_SHIFT) sc_q <= (sc_q == SHIFT_LAST) ? '0 : sc_q + 1'b1;
      if (st_q == ST_CAPT)  pc_q <= (pc_q == PAT_LAST) ? '0 : pc_q + 1'b1;
    end
  end

  assign count_o     = (st_q == ST_COUNT);
  assign shift_o     = (st_q == ST_SHIFT);
  assign capt_o      = (st_q == ST_CAPT);
  assign seed_step_o = capt_o && (pc_q == PAT_LAST);
endmodule

// File: rtl/scan_seed_seq.sv
module scan_seed_seq #(
  parameter int unsigned M_CHAINS  = 4,
  parameter int unsigned CHAIN_LEN = 6,
  parameter logic [M_CHAINS-1:0] TAPS = 4'b1100,
  parameter logic [M_CHAINS-1:0] SEED = 4'b0001
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  output logic [M_CHAINS-1:0] scan_data_o,
  output logic                scan_en_o,
  output logic                pattern_done_o,
  output logic                seed_step_o,
  output logic                fast_step_o
);
  // Johnson width never below chain count
  localparam int unsigned L = (CHAIN_LEN < M_CHAINS) ? M_CHAINS : CHAIN_LEN;

  logic                count, shift, capt, seed_step, j_msb;
  logic [M_CHAINS-1:0] seed_q;

  seq_ctrl #(.L(L)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .count_o(count), .shift_o(shift), .capt_o(capt), .seed_step_o(seed_step)
  );

  seed_lfsr #(.W(M_CHAINS), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
    .clk_i, .rst_ni, .step_i(seed_step), .seed_o(seed_q)
  );

  johnson_rcfg #(.L(L)) u_john (
    .clk_i, .rst_ni, .en_i(count | shift), .count_i(count), .msb_o(j_msb)
  );

  for (genvar k = 0; k < M_CHAINS; k++) begin : g_xor
    assign scan_data_o[k] = shift & (seed_q[k] ^ j_msb);
  end

  assign scan_en_o      = shift;
  assign pattern_done_o = capt;
  assign seed_step_o    = seed_step;
  assign fast_step_o    = count | shift;
endmodule

// File: rtl/scan_seed_seq_chk.sv
module scan_seed_seq_chk #(
  parameter int unsigned M = 4,
  parameter int unsigned L = 6
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [M-1:0] scan_data_o,
  input logic         scan_en_o,
  input logic         pattern_done_o,
  input logic         seed_step_o,
  input logic         fast_step_o,
  input logic [M-1:0] seed_i
);
  localparam int unsigned RW = $clog2(L + 1) + 1;
  logic [RW-1:0] run_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_len <= '0;
    else if (scan_en_o) run_len <= run_len + 1'b1;
    else                run_len <= '0;
  end

  // R2
  shift_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scan_en_o) |-> run_len == RW'(L));
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pattern_done_o |=> !pattern_done_o && fast_step_o && !scan_en_o);
  // R9
  done_after_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pattern_done_o) |-> $past(scan_en_o));
  // R7
  seed_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seed_step_o |=> $stable(seed_i));
  // R7
  seed_in_capt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_step_o |-> pattern_done_o);
  // R4
  data_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scan_en_o |-> scan_data_o == '0);
  // R8
  fast_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fast_step_o, pattern_done_o}) && (!scan_en_o || fast_step_o));
endmodule

bind scan_seed_seq scan_seed_seq_chk #(.M(M_CHAINS), .L(L)) u_chk (
  .clk_i, .rst_ni, .scan_data_o, .scan_en_o, .pattern_done_o,
  .seed_step_o, .fast_step_o, .seed_i(seed_q)
);

// File: tb/sim_scan_seed_seq.sv
module sim_scan_seed_seq;
  localparam int M = 4;
  localparam int L = 6;   // R3: max(6,4)
  localparam int P = 2 * L;
  localparam int PERIOD = 15 * P;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [M-1:0] scan_data_o;
  logic         scan_en_o, pattern_done_o, seed_step_o, fast_step_o;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  logic [L-1:0] mj;
  logic [M-1:0] ms;
  int           mpat;
  logic [M-1:0] frame0 [L];

  always #2 clk = ~clk;

  scan_seed_seq u0 (
    .clk_i(clk), .rst_ni, .start_i, .scan_data_o, .scan_en_o,
    .pattern_done_o, .seed_step_o, .fast_step_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(req, {scan_data_o, scan_en_o, pattern_done_o, seed_step_o, fast_step_o}, '0);
  endtask

  task automatic model_reset();
    mj = '0; ms = 4'b0001; mpat = 0;
  endtask

  // expects to be at the negedge of a count cycle
  task automatic run_frames(input int n, input bit cmp_period);
    for (int f = 0; f < n; f++) begin
      chk("R2 count cycle", {scan_en_o, fast_step_o, pattern_done_o}, 3'b010);
      mj = {mj[L-2:0], ~mj[L-1]};   // R5
      for (int i = 0; i < L; i++) begin
        @(negedge clk);
        chk("R2 shift", scan_en_o, 1'b1);
        chk("R8 fast in shift", fast_step_o, 1'b1);
        chk("R4 data", scan_data_o, ms ^ {M{mj[L-1-i]}});
        if (mpat == 0) frame0[i] = scan_data_o;
        if (cmp_period && mpat == PERIOD) chk("R10 period repeat", scan_data_o, frame0[i]);
      end
      @(negedge clk);
      chk("R9 done in capture", {pattern_done_o, scan_en_o, fast_step_o}, 3'b100);
      chk("R7 seed step", seed_step_o, ((mpat % P) == P - 1));
      if ((mpat % P) == P - 1) ms = {ms[M-2:0], ms[M-1] ^ ms[M-2]};   // R6
      mpat++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; start_i = 1'b0;
    repeat (3) @(negedge clk);
    chk_idle("R1 in reset");
    rst_ni = 1'b1;
    repeat (10) @(negedge clk);
    chk_idle("R1 idle without start");
  endtask

  task automatic t_start();
    model_reset();
    start_i = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_long_run();
    t_start();   // start_i left high: R10 ignored while running
    run_frames(PERIOD + 6, 1'b1);
    chk("R10 frames seen", mpat, PERIOD + 6);
  endtask

  task automatic t_mid_reset();
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b0; start_i = 1'b0;
    @(negedge clk);
    chk_idle("R11 reset mid run");
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk_idle("R11 idle after reset");
    t_start();
    start_i = 1'b0;
    run_frames(2 * P + 1, 1'b0);
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_long_run();
    t_mid_reset();
    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end
endmodule